// File: doc/BRIEF.md
# Regulator Fault Protection Controller

This block sits behind the analog comparators of a single-phase buck regulator and turns their digitized flags into a protective response. It takes an output-high trip flag and an output-low release flag for overvoltage, an undervoltage flag and an overcurrent flag, along with a one-clock tick at the start of every switching cycle. Undervoltage and overcurrent are qualified by counting those ticks. Overvoltage acts at once. A latched fault pulls the power-good indication low and takes over the gate-driver mode.

Each class of fault recovers in its own way. Undervoltage needs a run of consecutive bad cycles. Overcurrent keeps a net score that rises and falls, so short excursions decay away. Once the overvoltage latch is set, the drivers move between holding the low side on and tri-stating both switches, with hysteresis between the trip and release flags. Undervoltage and overcurrent latches clear when enable is dropped. Only the synchronous power-on reset clears the overvoltage latch. Under light load in a sleep state, a negative-current flag tri-states the drivers until the next switching cycle begins.

Detection is armed only while enable is high and the start-up sequencer reports that the regulator is running, so a soft-start ramp cannot trip undervoltage.

Top module: `vr_fault_guard`

## Requirements
- R1: After reset, `pg_low` is 0. Whenever `en` is low and no overvoltage latch is set, `drv_mode` reads 2. The encoding of `drv_mode` is 0 = normal switching, 1 = low side forced on, 2 = both drivers tri-stated.
- R2: No fault latch sets while `en` or `run` is low, whatever the comparator flags do.
- R3: The undervoltage latch sets on the tick at which `uv_flag` is seen high for the 33rd consecutive tick. Any tick with the flag low restarts the run from zero. The result shows at the outputs one clock after that tick.
- R4: While an undervoltage or overcurrent latch is set, `pg_low` is 1 and `drv_mode` is 2. Both latches clear while `en` is low, and they stay clear when `en` returns high.
- R5: The overcurrent score rises by one on each tick with `oc_flag` high. It falls by one, but not below 0, on each tick with the flag low. The latch sets on the tick where the score reaches 32.
- R6: While armed, `ov_trip` sets the overvoltage latch on the next clock, with no tick needed. The latch then gives `pg_low` = 1 and `drv_mode` = 1. Toggling `en` does not clear it. Only `rst_n` low clears it.
- R7: Once the overvoltage latch is set, `ov_release` high moves `drv_mode` from 1 to 2 on the next clock, and `ov_trip` high moves it back from 2 to 1 on the next clock. This repeats as often as the flags alternate.
- R8: With `sleep_mode` high, `neg_cur` high makes `drv_mode` read 2 from the next clock until the clock after the next tick on which `neg_cur` is low. With `sleep_mode` low, `neg_cur` has no effect.
- R9: The overvoltage drive mode takes priority over every other source of `drv_mode`. `pg_low` is 1 whenever any fault latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| en | input | 1 | Regulator enable; low clears undervoltage and overcurrent latches |
| run | input | 1 | Start-up sequencer reports steady running |
| cyc_tick | input | 1 | One-clock pulse at each switching-cycle start |
| ov_trip | input | 1 | Output above overvoltage trip level |
| ov_release | input | 1 | Output below overvoltage release level |
| uv_flag | input | 1 | Output below undervoltage level |
| oc_flag | input | 1 | Sensed current at or above the limit |
| sleep_mode | input | 1 | Deep or deeper sleep state active |
| neg_cur | input | 1 | Inductor current sensed negative |
| pg_low | output | 1 | Power-good forced low by a latched fault |
| drv_mode | output | 2 | Gate-driver mode: 0 normal, 1 force low, 2 tri-state |

## Verification
Two pairs of functions can act on the same clock. The 32nd overcurrent tick can land together with an overvoltage trip. The bench raises `ov_trip` on exactly that tick and expects both latches to set, with the drive reported as force-low and not tri-state. The diode-emulation request can also be present while an overvoltage latch is held. The bench asserts `neg_cur` in sleep at that point and expects `drv_mode` to stay at 1. A behavioural model run on every clock judges both cases, and so do explicit expected values.

// File: rtl/vfg_pkg.sv
// Shared definitions for the regulator fault protection controller.
// Assumes the gate-driver stage decodes the 2-bit mode exactly as encoded here.
package vfg_pkg;

    typedef enum logic [1:0] {
        DRV_NORMAL    = 2'd0,
        DRV_FORCE_LOW = 2'd1,
        DRV_OFF       = 2'd2
    } drv_mode_t;

endpackage

// File: rtl/fault_qualifier.sv
// Counts switching-cycle ticks to qualify a slow fault and holds a trip latch.
// UPDOWN=0: persistence counter; a clean tick restarts it; trips after LIMIT+1 bad ticks.
// UPDOWN=1: net score; rises on bad ticks, falls to a floor of 0; trips on reaching LIMIT.
// Assumes tick_i is a single-clock pulse and clear_i is held while the regulator is off.
module fault_qualifier #(
    parameter int LIMIT  = 32,
    parameter bit UPDOWN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic clear_i,
    input  logic tick_i,
    input  logic flag_i,
    output logic trip_o
);

    localparam int CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] LIM_C  = CW'(LIMIT);
    localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          set_raw;
    logic          trip_q;

    generate
        if (UPDOWN) begin : g_updown
            // Next score: up on bad tick, down toward zero on clean tick.
            always_comb begin
                cnt_d   = cnt_q;
                set_raw = 1'b0;
                if (tick_i && flag_i) begin
                    cnt_d   = cnt_q + 1'b1;
                    set_raw = (cnt_q == LIM_M1);
                end else if (tick_i) begin
                    cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
                end
            end
        end else begin : g_persist
            // Next run length: grows on bad tick, restarts on clean tick.
            always_comb begin
                cnt_d   = cnt_q;
                set_raw = 1'b0;
                if (tick_i && flag_i) begin
                    if (cnt_q == LIM_C) begin
                        set_raw = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end else if (tick_i) begin
                    cnt_d = '0;
                end
            end
        end
    endgenerate

    // Counter register: held at zero while disarmed or already tripped.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm_i || trip_q) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Trip latch: cleared by the regulator-off condition, set once qualified.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            trip_q <= 1'b0;
        end else if (arm_i && set_raw) begin
            trip_q <= 1'b1;
        end
    end

    assign trip_o = trip_q;

    // Guards R2, R3 and R5: a trip only follows an armed bad tick.
    a_r2_trip_needs_armed_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_q) |-> $past(arm_i && tick_i && flag_i));

    // Guards R4: a set latch survives until the clear condition.
    a_r4_trip_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_q && !clear_i) |=> trip_q);

    // Guards R3 and R5: the count stays within the qualification window.
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_C);

endmodule

// File: rtl/ov_guard.sv
// Overvoltage latch with hysteretic drive selection between force-low and tri-state.
// Assumes over_i and release_i come from two comparators and are never both high.
module ov_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic over_i,
    input  logic release_i,
    output logic latched_o,
    output logic tristate_o
);

    logic lat_q;
    logic tri_q;

    // Latch on trip; once latched, alternate drive with the trip/release flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= 1'b0;
            tri_q <= 1'b0;
        end else if (lat_q) begin
            if (!tri_q && release_i) begin
                tri_q <= 1'b1;
            end else if (tri_q && over_i) begin
                tri_q <= 1'b0;
            end
        end else if (arm_i && over_i) begin
            lat_q <= 1'b1;
            tri_q <= 1'b0;
        end
    end

    assign latched_o  = lat_q;
    assign tristate_o = tri_q;

    // R6: only power-on reset releases the latch.
    a_r6_ov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q |=> lat_q);

    // R6: entry always begins with the low side forced on.
    a_r6_entry_force_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_q) |-> !tri_q);

    // R7: tri-state is entered only after the release flag.
    a_r7_tri_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tri_q) |-> $past(release_i));

    // R7: leaving tri-state requires a renewed trip.
    a_r7_low_after_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && $fell(tri_q)) |-> $past(over_i));

endmodule

// File: rtl/diode_emul.sv
// Light-load diode emulation: a negative-current flag in sleep tri-states the drivers
// for the remainder of the current switching cycle.
// Assumes tick_i marks the first clock of each switching cycle.
module diode_emul (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic neg_i,
    input  logic tick_i,
    output logic hold_off_o
);

    logic hold_q;

    // Hold request: set by negative current, dropped at the cycle boundary or on wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= sleep_i && (neg_i || (hold_q && !tick_i));
        end
    end

    assign hold_off_o = hold_q;

    // R8: no request outside sleep.
    a_r8_only_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> $past(sleep_i));

    // R8: a new cycle without negative current ends the request.
    a_r8_ends_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && tick_i && !neg_i) |=> !hold_q);

endmodule

// File: rtl/vr_fault_guard.sv
// Top of the regulator fault protection controller.
// Qualifies undervoltage (persistence) and overcurrent (net score) on switching ticks,
// latches overvoltage at once, and selects the gate-driver mode by priority.
// Assumes all inputs are synchronous to clk and that rst_n is the power-on reset.
module vr_fault_guard #(
    parameter int UV_CYCLES = 32,
    parameter int OC_CYCLES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       run,
    input  logic       cyc_tick,
    input  logic       ov_trip,
    input  logic       ov_release,
    input  logic       uv_flag,
    input  logic       oc_flag,
    input  logic       sleep_mode,
    input  logic       neg_cur,
    output logic       pg_low,
    output logic [1:0] drv_mode
);

    import vfg_pkg::*;

    logic      armed;
    logic      uv_lat;
    logic      oc_lat;
    logic      ov_lat;
    logic      ov_tri;
    logic      de_off;
    drv_mode_t mode_sel;

    assign armed = en && run;

    fault_qualifier #(.LIMIT(UV_CYCLES), .UPDOWN(1'b0)) u_uv_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (armed),
        .clear_i (!en),
        .tick_i  (cyc_tick),
        .flag_i  (uv_flag),
        .trip_o  (uv_lat)
    );

    fault_qualifier #(.LIMIT(OC_CYCLES), .UPDOWN(1'b1)) u_oc_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (armed),
        .clear_i (!en),
        .tick_i  (cyc_tick),
        .flag_i  (oc_flag),
        .trip_o  (oc_lat)
    );

    ov_guard u_ov (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (armed),
        .over_i     (ov_trip),
        .release_i  (ov_release),
        .latched_o  (ov_lat),
        .tristate_o (ov_tri)
    );

    diode_emul u_de (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_i    (sleep_mode),
        .neg_i      (neg_cur),
        .tick_i     (cyc_tick),
        .hold_off_o (de_off)
    );

    // Driver-mode priority: overvoltage, then off states, then diode emulation.
    always_comb begin
        if (ov_lat) begin
            mode_sel = ov_tri ? DRV_OFF : DRV_FORCE_LOW;
        end else if (uv_lat || oc_lat || !en) begin
            mode_sel = DRV_OFF;
        end else if (de_off) begin
            mode_sel = DRV_OFF;
        end else begin
            mode_sel = DRV_NORMAL;
        end
    end

    assign drv_mode = mode_sel;
    assign pg_low   = uv_lat || oc_lat || ov_lat;

    // R9: forcing the low side on only happens with power-good pulled low.
    a_r9_force_low_implies_pg: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_mode == DRV_FORCE_LOW) |-> pg_low);

    // R4: a latched slow fault never lets the drivers switch.
    a_r4_latched_not_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_lat || oc_lat) |-> (drv_mode != DRV_NORMAL));

    // R1: the mode code stays within its three legal values.
    a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        drv_mode != 2'd3);

endmodule

// File: tb/vr_fault_guard_bench.sv
module vr_fault_guard_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, en, run, cyc_tick, ov_trip, ov_release;
    logic       uv_flag, oc_flag, sleep_mode, neg_cur;
    logic       pg_low;
    logic [1:0] drv_mode;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // Reference model state.
    int m_uvc = 0;
    int m_occ = 0;
    bit m_uvl = 0, m_ocl = 0, m_ovl = 0, m_ovt = 0, m_de = 0;

    vr_fault_guard u_vr_fault_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .run        (run),
        .cyc_tick   (cyc_tick),
        .ov_trip    (ov_trip),
        .ov_release (ov_release),
        .uv_flag    (uv_flag),
        .oc_flag    (oc_flag),
        .sleep_mode (sleep_mode),
        .neg_cur    (neg_cur),
        .pg_low     (pg_low),
        .drv_mode   (drv_mode)
    );

    function automatic int model_drv();
        if (m_ovl) return m_ovt ? 2 : 1;
        if (m_uvl || m_ocl || !en) return 2;
        if (m_de) return 2;
        return 0;
    endfunction

    function automatic int model_pg();
        return (m_uvl || m_ocl || m_ovl) ? 1 : 0;
    endfunction

    task automatic model_step();
        bit armed = en && run;
        int n_uvc = m_uvc, n_occ = m_occ;
        bit n_uvl = m_uvl, n_ocl = m_ocl, n_ovl = m_ovl, n_ovt = m_ovt;
        if (!rst_n) begin
            m_uvc = 0; m_occ = 0; m_uvl = 0; m_ocl = 0; m_ovl = 0; m_ovt = 0; m_de = 0;
            return;
        end
        if (!en) begin n_uvl = 0; n_ocl = 0; end
        if (!armed || m_uvl) n_uvc = 0;
        else if (cyc_tick) begin
            if (uv_flag) begin
                if (m_uvc == 32) n_uvl = 1; else n_uvc = m_uvc + 1;
            end else n_uvc = 0;
        end
        if (!armed || m_ocl) n_occ = 0;
        else if (cyc_tick) begin
            if (oc_flag) begin
                n_occ = m_occ + 1;
                if (n_occ == 32) n_ocl = 1;
            end else n_occ = (m_occ > 0) ? m_occ - 1 : 0;
        end
        if (m_ovl) begin
            if (!m_ovt && ov_release) n_ovt = 1;
            else if (m_ovt && ov_trip) n_ovt = 0;
        end else if (armed && ov_trip) begin
            n_ovl = 1; n_ovt = 0;
        end
        m_de  = sleep_mode && (neg_cur || (m_de && !cyc_tick));
        m_uvc = n_uvc; m_occ = n_occ; m_uvl = n_uvl; m_ocl = n_ocl;
        m_ovl = n_ovl; m_ovt = n_ovt;
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: drive tick, let the model follow the edge, compare away from the edge.
    task automatic step(bit t);
        cyc_tick = t;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(cur_req, "model pg*4+drv", int'(pg_low) * 4 + int'(drv_mode),
              model_pg() * 4 + model_drv());
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            step(1'b0); step(1'b0); step(1'b1);
        end
    endtask

    task automatic expect_out(string req, int pg, int drv);
        check(req, "pg_low", int'(pg_low), pg);
        check(req, "drv_mode", int'(drv_mode), drv);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; en = 0; run = 0; cyc_tick = 0; ov_trip = 0; ov_release = 0;
        uv_flag = 0; oc_flag = 0; sleep_mode = 0; neg_cur = 0;
        @(negedge clk);
        step(1'b0); step(1'b0);
        rst_n = 1; step(1'b0);
        // R1: reset state, disabled drivers tri-stated.
        expect_out("R1", 0, 2);
        en = 1; step(1'b0);
        expect_out("R1", 0, 0);

        // R2: flags ignored before the sequencer reports running.
        cur_req = "R2";
        uv_flag = 1; oc_flag = 1; ov_trip = 1;
        ticks(40);
        expect_out("R2", 0, 0);
        uv_flag = 0; oc_flag = 0; ov_trip = 0;
        run = 1; step(1'b0);

        // R3: 32 bad ticks do not trip, the 33rd does.
        cur_req = "R3";
        uv_flag = 1; ticks(32);
        expect_out("R3", 0, 0);
        ticks(1);
        expect_out("R3", 1, 2);

        // R4: enable low clears the undervoltage latch.
        cur_req = "R4";
        uv_flag = 0; en = 0; step(1'b0);
        expect_out("R4", 0, 2);
        en = 1; step(1'b0);
        expect_out("R4", 0, 0);

        // R3: a clean tick restarts the run.
        cur_req = "R3";
        uv_flag = 1; ticks(20);
        uv_flag = 0; ticks(1);
        uv_flag = 1; ticks(20);
        expect_out("R3", 0, 0);
        uv_flag = 0; ticks(1);

        // R5: net score 20 - 10 + 21 = 31 holds, one more trips.
        cur_req = "R5";
        oc_flag = 1; ticks(20);
        oc_flag = 0; ticks(10);
        oc_flag = 1; ticks(21);
        expect_out("R5", 0, 0);
        ticks(1);
        expect_out("R5", 1, 2);

        // R4: enable toggle clears the overcurrent latch.
        cur_req = "R4";
        oc_flag = 0; en = 0; step(1'b0);
        en = 1; step(1'b0);
        expect_out("R4", 0, 0);

        // R5: score floors at zero.
        cur_req = "R5";
        ticks(50);
        oc_flag = 1; ticks(31);
        expect_out("R5", 0, 0);
        oc_flag = 0; ticks(40);

        // R8: negative current in sleep tri-states until the next tick.
        cur_req = "R8";
        sleep_mode = 1; neg_cur = 1; step(1'b0);
        expect_out("R8", 0, 2);
        neg_cur = 0; step(1'b0);
        expect_out("R8", 0, 2);
        step(1'b1);
        expect_out("R8", 0, 0);
        sleep_mode = 0; neg_cur = 1; step(1'b0);
        expect_out("R8", 0, 0);
        neg_cur = 0; step(1'b0);

        // R9: overvoltage and the 32nd overcurrent tick land together.
        cur_req = "R9";
        oc_flag = 1; ticks(31);
        step(1'b0); step(1'b0);
        ov_trip = 1; step(1'b1);
        expect_out("R9", 1, 1);
        ov_trip = 0; oc_flag = 0;

        // R7: hysteretic alternation.
        cur_req = "R7";
        ov_release = 1; step(1'b0);
        expect_out("R7", 1, 2);
        ov_release = 0; step(1'b0);
        expect_out("R7", 1, 2);
        ov_trip = 1; step(1'b0);
        expect_out("R7", 1, 1);
        ov_trip = 0; ov_release = 1; step(1'b0);
        expect_out("R7", 1, 2);
        ov_release = 0; ov_trip = 1; step(1'b0);
        ov_trip = 0;

        // R6: enable toggle leaves overvoltage latched.
        cur_req = "R6";
        en = 0; step(1'b0);
        en = 1; step(1'b0);
        expect_out("R6", 1, 1);

        // R9: diode emulation cannot override overvoltage drive.
        cur_req = "R9";
        sleep_mode = 1; neg_cur = 1; step(1'b0); step(1'b0);
        expect_out("R9", 1, 1);
        sleep_mode = 0; neg_cur = 0;

        // R6: power-on reset clears; a fresh trip acts without a tick.
        cur_req = "R6";
        rst_n = 0; step(1'b0);
        rst_n = 1; step(1'b0);
        expect_out("R6", 0, 0);
        ov_trip = 1; step(1'b0);
        expect_out("R6", 1, 1);
        ov_trip = 0; step(1'b0);

        finish_run();
    end

endmodule